// File: doc/BRIEF.md
# Host Bridge Address Map Translator

This block sits between the processor side of a processor-to-PCI host bridge and its PCI master logic. It decides which address map is in force and, for every processor address, which region the address falls in. The regions are system memory, PCI I/O, PCI memory and boot ROM. The block then produces the address to present on the PCI side. Region, PCI address and unmapped flag are combinational functions of the processor address and of a small set of control registers.

The map in force starts out from a strap pin that is latched while reset is held. Map A is chosen when the strap is high and map B when it is low. Software can later replace that choice through a write port. The third map, a software emulation layout, cannot be reached from the strap. It is only entered by setting an emulation-enable bit. In map A the PCI I/O window can be translated in one of two ways. The first is contiguous, a plain offset. The second is discontiguous, where each 32-byte I/O block gets a 4 KB processor page of its own, so page-level protection can be applied per block of legacy port space.

Top module: `hb_addr_xlat`

## Requirements
- R1: While `rst_n` is low the strap is sampled on every clock edge. After reset the map is A (`map_mode`=0) if the strap was high and B (`map_mode`=1) if it was low. The discontiguous and emulation bits reset to 0.
- R2: Changes on `strap_map_a` after reset have no effect on `map_mode` or on translation.
- R3: A write (`cfg_we`=1) updates control at the next rising edge: bit0 selects the map (1=A, 0=B), bit1 enables discontiguous I/O, bit2 enables emulation. With `cfg_we`=0 the control state holds.
- R4: When bit2 is set, `map_mode` is 2 (emulation) whatever bit0 holds.
- R5: In map A the regions are memory 0x00000000–0x7FFFFFFF (PCI address equals CPU address), I/O 0x80000000–0x9FFFFFFF, PCI memory 0xC0000000–0xFEFFFFFF (PCI address = CPU − 0xC0000000) and ROM 0xFF000000–0xFFFFFFFF (passed through). The region codes are 0=memory, 1=I/O, 2=PCI memory, 3=ROM.
- R6: In map A with discontiguous off, the PCI I/O address is CPU − 0x80000000.
- R7: In map A with discontiguous on, the PCI I/O address is ((CPU − 0x80000000) >> 12) × 32 + CPU[4:0].
- R8: In map B, memory is 0x00000000–0x7FFFFFFF and PCI memory is 0x80000000–0xFCFFFFFF, both passed through. I/O is 0xFE000000–0xFEBFFFFF with PCI address = CPU − 0xFE000000. ROM is 0xFF000000 upward, passed through. The discontiguous bit has no effect in map B.
- R9: In the emulation map, memory is 0x00000000–0x3FFFFFFF (passed through) and I/O is 0x40000000–0x4000FFFF (PCI address = CPU − 0x40000000). PCI memory is 0x80000000–0xFEFFFFFF (PCI address = CPU − 0x80000000) and ROM is 0xFF000000 upward (passed through).
- R10: An address in no window of the active map sets `unmapped`=1 and drives `region`=0 and `pci_addr`=0. Otherwise `unmapped`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; strap is sampled while low |
| strap_map_a | input | 1 | Reset strap: 1 selects map A, 0 selects map B |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 3 | Control data: bit0 map A select, bit1 discontiguous I/O, bit2 emulation |
| cpu_addr | input | 32 | Processor address |
| map_mode | output | 2 | Active map: 0=A, 1=B, 2=emulation |
| region | output | 2 | Region code: 0 memory, 1 PCI I/O, 2 PCI memory, 3 ROM |
| unmapped | output | 1 | Address lies outside every window of the active map |
| pci_addr | output | 32 | Translated PCI-side address |

## Verification
A bad control register shows up on `map_mode` in the cycle after the reset release or write that should have set it. From then on it also shows up in the region and address of every access that falls where the maps differ. A wrong discontiguous bit only shows in map A I/O accesses, where the low five bits survive but the upper bits collapse or spread. The address path has no state, so a window-limit or offset error appears at once, for the same address. Accesses at the first and last byte of each window expose off-by-one limits right away.

// File: rtl/hb_xlat_pkg.sv
package hb_xlat_pkg;

  localparam int ADDR_W  = 32;
  localparam int CFG_W   = 3;
  localparam int BLK_W   = 5;   // 32-byte I/O block
  localparam int PAGE_W  = 12;  // 4 KB processor page
  localparam int NUM_MAP = 3;

  // control word bit positions (decoded by the control register)
  localparam int CFG_SEL_A = 0;
  localparam int CFG_DISC  = 1;
  localparam int CFG_EMU   = 2;

  typedef enum logic [1:0] {
    MAP_A   = 2'd0,
    MAP_B   = 2'd1,
    MAP_EMU = 2'd2
  } map_e;

  typedef enum logic [1:0] {
    RG_MEM  = 2'd0,
    RG_IO   = 2'd1,
    RG_PMEM = 2'd2,
    RG_ROM  = 2'd3
  } region_e;

  typedef struct packed {
    logic    hit;
    region_e rg;
  } cls_t;

  typedef logic [ADDR_W-1:0] addr_t;

  // window limits, map A
  localparam addr_t A_MEM_HI  = 32'h7FFF_FFFF;
  localparam addr_t A_IO_LO   = 32'h8000_0000;
  localparam addr_t A_IO_HI   = 32'h9FFF_FFFF;
  localparam addr_t A_PM_LO   = 32'hC000_0000;
  localparam addr_t A_PM_HI   = 32'hFEFF_FFFF;
  localparam addr_t ROM_LO    = 32'hFF00_0000;
  // map B
  localparam addr_t B_MEM_HI  = 32'h7FFF_FFFF;
  localparam addr_t B_PM_LO   = 32'h8000_0000;
  localparam addr_t B_PM_HI   = 32'hFCFF_FFFF;
  localparam addr_t B_IO_LO   = 32'hFE00_0000;
  localparam addr_t B_IO_HI   = 32'hFEBF_FFFF;
  // emulation map
  localparam addr_t E_MEM_HI  = 32'h3FFF_FFFF;
  localparam addr_t E_IO_LO   = 32'h4000_0000;
  localparam addr_t E_IO_HI   = 32'h4000_FFFF;
  localparam addr_t E_PM_LO   = 32'h8000_0000;
  localparam addr_t E_PM_HI   = 32'hFEFF_FFFF;

  function automatic logic in_win(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic cls_t mk_cls(logic hit, region_e rg);
    cls_t c;
    c.hit = hit;
    c.rg  = hit ? rg : RG_MEM;
    return c;
  endfunction

  function automatic cls_t classify(map_e m, addr_t a);
    cls_t c;
    c = mk_cls(1'b0, RG_MEM);
    unique case (m)
      MAP_A: begin
        if (a <= A_MEM_HI)                     c = mk_cls(1'b1, RG_MEM);
        else if (in_win(a, A_IO_LO, A_IO_HI))  c = mk_cls(1'b1, RG_IO);
        else if (in_win(a, A_PM_LO, A_PM_HI))  c = mk_cls(1'b1, RG_PMEM);
        else if (a >= ROM_LO)                  c = mk_cls(1'b1, RG_ROM);
      end
      MAP_B: begin
        if (a <= B_MEM_HI)                     c = mk_cls(1'b1, RG_MEM);
        else if (in_win(a, B_PM_LO, B_PM_HI))  c = mk_cls(1'b1, RG_PMEM);
        else if (in_win(a, B_IO_LO, B_IO_HI))  c = mk_cls(1'b1, RG_IO);
        else if (a >= ROM_LO)                  c = mk_cls(1'b1, RG_ROM);
      end
      MAP_EMU: begin
        if (a <= E_MEM_HI)                     c = mk_cls(1'b1, RG_MEM);
        else if (in_win(a, E_IO_LO, E_IO_HI))  c = mk_cls(1'b1, RG_IO);
        else if (in_win(a, E_PM_LO, E_PM_HI))  c = mk_cls(1'b1, RG_PMEM);
        else if (a >= ROM_LO)                  c = mk_cls(1'b1, RG_ROM);
      end
      default: c = mk_cls(1'b0, RG_MEM);
    endcase
    return c;
  endfunction

  // discontiguous I/O: page index of the window offset picks the 32-byte block
  function automatic addr_t io_spread(addr_t a, addr_t base);
    addr_t off;
    addr_t r;
    off = a - base;
    r   = (off >> PAGE_W) << BLK_W;
    r[BLK_W-1:0] = a[BLK_W-1:0];
    return r;
  endfunction

  function automatic addr_t io_flat(addr_t a, addr_t base);
    return a - base;
  endfunction

endpackage

// File: rtl/hb_xlat_ctrl.sv
module hb_xlat_ctrl
  import hb_xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_map_a,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output map_e             map_mode,
  output logic             disc_en,
  output logic             emu_en
);

  logic sel_a_q;
  logic disc_q;
  logic emu_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_a_q <= strap_map_a;
      disc_q  <= 1'b0;
      emu_q   <= 1'b0;
    end else if (cfg_we) begin
      sel_a_q <= cfg_wdata[CFG_SEL_A];
      disc_q  <= cfg_wdata[CFG_DISC];
      emu_q   <= cfg_wdata[CFG_EMU];
    end
  end

  always_comb begin
    if (emu_q)        map_mode = MAP_EMU;
    else if (sel_a_q) map_mode = MAP_A;
    else              map_mode = MAP_B;
  end

  assign disc_en = disc_q;
  assign emu_en  = emu_q;

endmodule

// File: rtl/hb_xlat_classify.sv
module hb_xlat_classify
  import hb_xlat_pkg::*;
(
  input  addr_t   cpu_addr,
  input  map_e    map_mode,
  output logic    hit,
  output region_e region
);

  cls_t per_map [NUM_MAP];

  for (genvar g = 0; g < NUM_MAP; g++) begin : g_map
    assign per_map[g] = classify(map_e'(g), cpu_addr);
  end

  always_comb begin
    hit    = 1'b0;
    region = RG_MEM;
    for (int i = 0; i < NUM_MAP; i++) begin
      if (map_mode == map_e'(i)) begin
        hit    = per_map[i].hit;
        region = per_map[i].rg;
      end
    end
  end

endmodule

// File: rtl/hb_xlat_calc.sv
module hb_xlat_calc
  import hb_xlat_pkg::*;
(
  input  addr_t   cpu_addr,
  input  map_e    map_mode,
  input  logic    disc_en,
  input  logic    hit,
  input  region_e region,
  output addr_t   pci_addr
);

  addr_t io_a;
  addr_t io_b;
  addr_t io_e;
  addr_t pm_a;
  addr_t pm_e;

  assign io_a = disc_en ? io_spread(cpu_addr, A_IO_LO) : io_flat(cpu_addr, A_IO_LO);
  assign io_b = io_flat(cpu_addr, B_IO_LO);
  assign io_e = io_flat(cpu_addr, E_IO_LO);
  assign pm_a = cpu_addr - A_PM_LO;
  assign pm_e = cpu_addr - E_PM_LO;

  always_comb begin
    pci_addr = '0;
    if (hit) begin
      unique case (region)
        RG_IO: begin
          unique case (map_mode)
            MAP_A:   pci_addr = io_a;
            MAP_B:   pci_addr = io_b;
            default: pci_addr = io_e;
          endcase
        end
        RG_PMEM: begin
          unique case (map_mode)
            MAP_A:   pci_addr = pm_a;
            MAP_B:   pci_addr = cpu_addr;
            default: pci_addr = pm_e;
          endcase
        end
        default: pci_addr = cpu_addr;  // memory and ROM pass through
      endcase
    end
  end

endmodule

// File: rtl/hb_addr_xlat.sv
module hb_addr_xlat
  import hb_xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_map_a,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic [1:0]        map_mode,
  output logic [1:0]        region,
  output logic              unmapped,
  output logic [ADDR_W-1:0] pci_addr
);

  map_e    mode_w;
  logic    disc_w;
  logic    emu_w;
  logic    hit_w;
  region_e rg_w;
  addr_t   pci_w;

  hb_xlat_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_map_a (strap_map_a),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .map_mode    (mode_w),
    .disc_en     (disc_w),
    .emu_en      (emu_w)
  );

  hb_xlat_classify u_cls (
    .cpu_addr (cpu_addr),
    .map_mode (mode_w),
    .hit      (hit_w),
    .region   (rg_w)
  );

  hb_xlat_calc u_calc (
    .cpu_addr (cpu_addr),
    .map_mode (mode_w),
    .disc_en  (disc_w),
    .hit      (hit_w),
    .region   (rg_w),
    .pci_addr (pci_w)
  );

  assign map_mode = mode_w;
  assign region   = rg_w;
  assign unmapped = !hit_w;
  assign pci_addr = pci_w;

endmodule

// File: rtl/hb_xlat_chk.sv
module hb_xlat_chk
  import hb_xlat_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              strap_map_a,
  input logic              cfg_we,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [1:0]        map_mode,
  input logic [1:0]        region,
  input logic              unmapped,
  input logic [ADDR_W-1:0] pci_addr,
  input logic              disc_en,
  input logic              emu_en
);

  assert_strap_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (map_mode == ($past(strap_map_a) ? 2'd0 : 2'd1)) && !disc_en && !emu_en);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_we)) |-> $stable(map_mode));

  assert_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[CFG_EMU]) |=> map_mode == ($past(cfg_wdata[CFG_SEL_A]) ? 2'd0 : 2'd1));

  assert_emu_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[CFG_EMU]) |=> map_mode == 2'd2);

  assert_disc_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (map_mode == 2'd0 && disc_en && region == 2'd1 && !unmapped) |->
      (pci_addr[BLK_W-1:0] == cpu_addr[BLK_W-1:0]) && (pci_addr[ADDR_W-1:22] == '0));

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (pci_addr == '0) && (region == 2'd0));

  assert_rom_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (region == 2'd3 && !unmapped) |-> pci_addr == cpu_addr);

endmodule

bind hb_addr_xlat hb_xlat_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .strap_map_a (strap_map_a),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .cpu_addr    (cpu_addr),
  .map_mode    (map_mode),
  .region      (region),
  .unmapped    (unmapped),
  .pci_addr    (pci_addr),
  .disc_en     (disc_w),
  .emu_en      (emu_w)
);

// File: tb/hb_addr_xlat_bench.sv
module hb_addr_xlat_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_map_a = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_wdata = '0;
  logic [31:0] cpu_addr = '0;
  logic [1:0]  map_mode;
  logic [1:0]  region;
  logic        unmapped;
  logic [31:0] pci_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hb_addr_xlat u_hb_addr_xlat (
    .clk(clk), .rst_n(rst_n), .strap_map_a(strap_map_a),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cpu_addr(cpu_addr),
    .map_mode(map_mode), .region(region), .unmapped(unmapped), .pci_addr(pci_addr)
  );

  // model state tracked by the bench: mode 0=A 1=B 2=emu
  int unsigned m_mode;
  bit          m_disc;

  // expected {unmapped, region, pci}
  function automatic logic [34:0] model(int unsigned md, bit disc, logic [31:0] a);
    logic [7:0] top = a[31:24];
    if (md == 0) begin
      if (!a[31])                       return {1'b0, 2'd0, a};
      if (a[31:29] == 3'b100)
        return disc ? {1'b0, 2'd1, 32'((a[28:12]) * 32 + a[4:0])}
                    : {1'b0, 2'd1, {3'b000, a[28:0]}};
      if (top == 8'hFF)                 return {1'b0, 2'd3, a};
      if (a[31:30] == 2'b11)            return {1'b0, 2'd2, {2'b00, a[29:0]}};
      return 35'd0 | (35'd1 << 34);
    end else if (md == 1) begin
      if (!a[31])                       return {1'b0, 2'd0, a};
      if (top <= 8'hFC)                 return {1'b0, 2'd2, a};
      if (top == 8'hFF)                 return {1'b0, 2'd3, a};
      if (top == 8'hFE && a[23:22] != 2'b11)
        return {1'b0, 2'd1, {8'h00, a[23:0]}};
      return 35'd1 << 34;
    end else begin
      if (a[31:30] == 2'b00)            return {1'b0, 2'd0, a};
      if (a[31:16] == 16'h4000)         return {1'b0, 2'd1, {16'h0, a[15:0]}};
      if (top == 8'hFF)                 return {1'b0, 2'd3, a};
      if (a[31])                        return {1'b0, 2'd2, {1'b0, a[30:0]}};
      return 35'd1 << 34;
    end
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic probe(logic [31:0] a, string req);
    logic [34:0] e;
    @(negedge clk);
    cpu_addr = a;
    #5;
    e = model(m_mode, m_disc, a);
    chk({unmapped, region, pci_addr} == e, req,
        {29'd0, unmapped, region, pci_addr}, {29'd0, e});
  endtask

  task automatic wr(logic [2:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    cfg_wdata = '0;
    m_mode = d[2] ? 2 : (d[0] ? 0 : 1);
    m_disc = d[1];
    #5;
    chk(map_mode == 2'(m_mode), d[2] ? "R4" : "R3", 64'(map_mode), 64'(m_mode));
  endtask

  task automatic do_reset(bit s);
    @(negedge clk);
    rst_n = 1'b0;
    strap_map_a = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_mode = s ? 0 : 1;
    m_disc = 1'b0;
    #5;
    chk(map_mode == 2'(m_mode), "R1", 64'(map_mode), 64'(m_mode));
  endtask

  task automatic rand_run(int n, string req);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a = $urandom();
      if (i % 3 == 1) a[31:24] = 8'(i * 37);  // spread over window tops
      probe(a, req);
    end
  endtask

  initial begin
    void'($urandom(32'd12345));
    m_mode = 0;
    m_disc = 0;
    do_reset(1'b1);
    // R1: discontiguous bit starts clear -> contiguous I/O in map A
    probe(32'h8000_1234, "R1");

    // R2: strap toggles ignored
    strap_map_a = 1'b0;
    repeat (4) @(negedge clk);
    #5 chk(map_mode == 2'd0, "R2", 64'(map_mode), 64'd0);
    probe(32'h9000_0040, "R2");

    // R5/R6 map A contiguous, window edges
    probe(32'h7FFF_FFFF, "R5");
    probe(32'h8000_0000, "R6");
    probe(32'h9FFF_FFFF, "R6");
    probe(32'hA000_0000, "R10");
    probe(32'hBFFF_FFFF, "R10");
    probe(32'hC000_0000, "R5");
    probe(32'hFEFF_FFFF, "R5");
    probe(32'hFF00_0000, "R5");
    probe(32'hFFFF_FFFF, "R5");
    rand_run(150, "R5");

    // R7 map A discontiguous
    wr(3'b011);
    probe(32'h8000_0000, "R7");
    probe(32'h8000_101F, "R7");
    probe(32'h8001_F3E7, "R7");
    probe(32'h9FFF_FFFF, "R7");
    rand_run(150, "R7");

    // R8 map B, discontiguous bit set must not matter
    wr(3'b010);
    probe(32'h8000_0000, "R8");
    probe(32'hFCFF_FFFF, "R8");
    probe(32'hFD00_0000, "R10");
    probe(32'hFE00_0000, "R8");
    probe(32'hFEBF_FFFF, "R8");
    probe(32'hFEC0_0000, "R10");
    probe(32'hFF00_0004, "R8");
    rand_run(150, "R8");

    // R4 emulation wins over map select; R9 emulation map
    wr(3'b101);
    probe(32'h3FFF_FFFF, "R9");
    probe(32'h4000_0000, "R9");
    probe(32'h4000_FFFF, "R9");
    probe(32'h4001_0000, "R10");
    probe(32'h7FFF_FFFF, "R10");
    probe(32'h8000_0000, "R9");
    probe(32'hFEFF_FFFF, "R9");
    probe(32'hFF12_3456, "R9");
    rand_run(150, "R9");

    // R3 leave emulation, back to map A contiguous; no-write hold
    wr(3'b001);
    repeat (3) @(negedge clk);
    #5 chk(map_mode == 2'd0, "R3", 64'(map_mode), 64'd0);
    probe(32'h8000_1234, "R6");

    // R1 strap low selects map B
    do_reset(1'b0);
    probe(32'h8000_0000, "R8");
    strap_map_a = 1'b1;
    repeat (2) @(negedge clk);
    probe(32'hFE00_0010, "R2");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule